// File: doc/BRIEF.md
# Multi-Source Event Builder

The block collects one frame from each of N stream sources and sends them as a group, called an event, to one shared output. It sends nothing for an event until every source that takes part has a frame waiting at its input. It then forwards those frames whole, in rising source index. The output destination tag of each frame is rewritten per source. In indexed mode the tag is the number of the source. In routed mode each tag bit is either forced to a constant or copied from the incoming tag. Which bits are forced, and to what value, is set per source by parameters.

Some frames do not belong to any event. These are frames whose incoming tag equals a programmable transition value, and the block forwards each one alone with its tag unchanged. Any source can be taken out of event building with a bypass bit. The block accepts and discards that source's traffic and counts the discarded frames. When some sources have a frame waiting but others stay empty for a parameterised number of cycles, the block discards the waiting frames. It then counts a timeout and returns to collecting. Both counters are output as status and are zeroed by a clear strobe.

Top module: `event_builder`

## Requirements
- R1: While reset is held, and in the first cycle after it, `m_valid` is low and both counters read zero.
- R2: Output starts for an event only once every non-bypassed source presents a non-transition frame. The event's frames then appear complete and back to back, in ascending source index, and none is split or interleaved.
- R3: With `route_mode` = 0, every event frame carries `m_dest` equal to its source index (source 0 gives 0, source 2 gives 2).
- R4: With `route_mode` = 1, bit b of `m_dest` takes the value of bit b of `ROUTE_VAL` for the source when bit b of `ROUTE_MASK` is 1, and otherwise takes bit b of the incoming tag. Defaults with DW = 4: source 0 uses mask 4'b1100 and value 4'b0100; source 1 uses mask 4'b1111 and value 4'b1010; source 2 uses mask 4'b0000.
- R5: A frame at the head of a non-bypassed source whose tag equals `trans_dest` is forwarded alone, with `m_dest` equal to `trans_dest`. It goes ahead of an event that is ready in the same cycle, and the lowest such source goes first.
- R6: A source with its `bypass_en` bit at 1 has `s_ready` high at all times. Its frames never reach the output, and `byp_drop_cnt` rises by one for each of its frames whose last beat is accepted.
- R7: When at least one source but not all non-bypassed sources present a frame for `TMO_CYC` consecutive collecting cycles, the present frames are consumed without output and `tmo_cnt` rises by one. The event that follows is built normally.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_last` and `m_dest` hold. Beats are never lost, duplicated or reordered.
- R9: Counters are 32 bits wide and stop at all ones. `cnt_clr` zeroes them, and in a cycle with both a clear and an increment, the counter ends at the size of that increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_valid | input | 3 | Per-source beat valid |
| s_ready | output | 3 | Per-source beat ready |
| s_data | input | 48 | Per-source data, source i in bits [16i+15:16i] |
| s_last | input | 3 | Per-source last beat of frame |
| s_dest | input | 12 | Per-source destination tag, source i in bits [4i+3:4i] |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Output beat ready |
| m_data | output | 16 | Output data |
| m_last | output | 1 | Output last beat of frame |
| m_dest | output | 4 | Output destination tag after remap |
| bypass_en | input | 3 | Per-source bypass |
| route_mode | input | 1 | 0 indexed tag, 1 routed tag |
| trans_dest | input | 4 | Tag value marking transition frames |
| cnt_clr | input | 1 | Counter clear strobe |
| byp_drop_cnt | output | 32 | Frames discarded from bypassed sources |
| tmo_cnt | output | 32 | Events discarded on timeout |

## Verification
A counter clear and a counter increment can fall in the same cycle. The bench provokes this by presenting a single-beat frame on a bypassed source in the same cycle that it pulses `cnt_clr`, so the frame is accepted at the clearing edge. It judges the result by reading `byp_drop_cnt` as 1. A second collision is a transition frame arriving in the same cycle that an event becomes complete. The bench creates it by loading a transition frame and a full set of event frames together, and expects the transition frame to appear first with its tag unchanged.

// File: rtl/eb_pkg.sv
package eb_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_SEND    = 2'd1,
    ST_TRANS   = 2'd2,
    ST_DROP    = 2'd3
  } eb_state_t;
endpackage

// File: rtl/eb_remap.sv
module eb_remap #(
  parameter int N  = 3,
  parameter int DW = 4,
  parameter logic [N*DW-1:0] ROUTE_MASK = '0,
  parameter logic [N*DW-1:0] ROUTE_VAL  = '0
) (
  input  logic            route_mode,
  input  logic [N*DW-1:0] in_dest,
  output logic [N*DW-1:0] out_dest
);
  for (genvar i = 0; i < N; i++) begin : g_src
    localparam logic [DW-1:0] MSK = ROUTE_MASK[i*DW +: DW];
    localparam logic [DW-1:0] VAL = ROUTE_VAL[i*DW +: DW];
    logic [DW-1:0] routed;
    assign routed = (in_dest[i*DW +: DW] & ~MSK) | (VAL & MSK);
    assign out_dest[i*DW +: DW] = route_mode ? routed : DW'(i);
  end
endmodule

// File: rtl/eb_sat_cnt.sv
module eb_sat_cnt #(
  parameter int W  = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  cnt
);
  localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;
  logic         cnt_en;

  always_comb begin
    sum    = (clr ? '0 : {1'b0, cnt_q}) + (W+1)'(inc);
    cnt_d  = (sum > MAXV) ? MAXV[W-1:0] : sum[W-1:0];
    cnt_en = clr || (inc != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_hold_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_q == MAXV[W-1:0]) |=> cnt_q == MAXV[W-1:0]);
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == W'($past(inc)));
endmodule

// File: rtl/eb_ctrl.sv
module eb_ctrl
  import eb_pkg::*;
#(
  parameter int N       = 3,
  parameter int DW      = 4,
  parameter int TMO_CYC = 64,
  localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    s_valid,
  input  logic [N-1:0]    s_last,
  input  logic [N*DW-1:0] s_dest,
  input  logic [N-1:0]    bypass,
  input  logic [DW-1:0]   trans_dest,
  input  logic            m_ready,
  output logic [N-1:0]    s_ready,
  output logic [IW-1:0]   cur,
  output logic            fwd,
  output logic            is_trans,
  output logic            tmo_hit
);
  localparam int            TW       = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

  eb_state_t     st_q, st_d;
  logic [IW-1:0] cur_q, cur_d;
  logic [N-1:0]  drop_q, drop_d;
  logic [TW-1:0] tmr_q, tmr_d;

  logic [N-1:0]  head_trans, present, active;
  logic          all_in, any_in, beat, done, have_next;
  logic [IW-1:0] first_trans, first_act, next_act;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      head_trans[i] = s_valid[i] && !bypass[i] && (s_dest[i*DW +: DW] == trans_dest);
      present[i]    = s_valid[i] && !bypass[i] && (s_dest[i*DW +: DW] != trans_dest);
    end
    active      = ~bypass;
    all_in      = (|active) && (present == active);
    any_in      = |present;
    first_trans = '0;
    first_act   = '0;
    next_act    = '0;
    have_next   = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (head_trans[i]) first_trans = IW'(i);
      if (active[i]) first_act = IW'(i);
      if (active[i] && (i > int'(cur_q))) begin
        next_act  = IW'(i);
        have_next = 1'b1;
      end
    end
    beat = s_valid[cur_q] && m_ready;
    done = beat && s_last[cur_q];
  end

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    drop_d  = drop_q;
    tmr_d   = tmr_q;
    tmo_hit = 1'b0;
    unique case (st_q)
      ST_COLLECT: begin
        if (|head_trans) begin
          st_d  = ST_TRANS;
          cur_d = first_trans;
        end else if (all_in) begin
          st_d  = ST_SEND;
          cur_d = first_act;
          tmr_d = '0;
        end else if (any_in) begin
          if (tmr_q == TMO_LAST) begin
            st_d    = ST_DROP;
            drop_d  = present;
            tmr_d   = '0;
            tmo_hit = 1'b1;
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end else begin
          tmr_d = '0;
        end
      end
      ST_SEND: begin
        if (done) begin
          if (have_next) cur_d = next_act;
          else st_d = ST_COLLECT;
        end
      end
      ST_TRANS: begin
        if (done) st_d = ST_COLLECT;
      end
      ST_DROP: begin
        drop_d = drop_q & ~(s_valid & s_last);
        if (drop_d == '0) st_d = ST_COLLECT;
      end
      default: st_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_COLLECT;
      cur_q  <= '0;
      drop_q <= '0;
      tmr_q  <= '0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      drop_q <= drop_d;
      tmr_q  <= tmr_d;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      s_ready[i] = bypass[i]
                || (((st_q == ST_SEND) || (st_q == ST_TRANS)) && (cur_q == IW'(i)) && m_ready)
                || ((st_q == ST_DROP) && drop_q[i]);
    end
  end

  assign cur      = cur_q;
  assign is_trans = (st_q == ST_TRANS);
  assign fwd      = ((st_q == ST_SEND) || (st_q == ST_TRANS)) && s_valid[cur_q];

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COLLECT && head_trans == '0 && all_in) |=> st_q == ST_SEND);
  assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && done && st_d == ST_SEND) |=> cur_q > $past(cur_q));
  assert_trans_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COLLECT && (|head_trans)) |=> st_q == ST_TRANS);
  assert_tmo_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> (st_q == ST_DROP) && !fwd);
  assert_one_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_DROP) |-> $onehot0(s_ready & ~bypass));
endmodule

// File: rtl/event_builder.sv
module event_builder #(
  parameter int N       = 3,
  parameter int W       = 16,
  parameter int DW      = 4,
  parameter int TMO_CYC = 64,
  parameter int CW      = 32,
  parameter logic [N*DW-1:0] ROUTE_MASK = 12'h0FC,
  parameter logic [N*DW-1:0] ROUTE_VAL  = 12'h0A4
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic [N-1:0]    s_valid,
  output logic [N-1:0]    s_ready,
  input  logic [N*W-1:0]  s_data,
  input  logic [N-1:0]    s_last,
  input  logic [N*DW-1:0] s_dest,
  output logic            m_valid,
  input  logic            m_ready,
  output logic [W-1:0]    m_data,
  output logic            m_last,
  output logic [DW-1:0]   m_dest,
  input  logic [N-1:0]    bypass_en,
  input  logic            route_mode,
  input  logic [DW-1:0]   trans_dest,
  input  logic            cnt_clr,
  output logic [CW-1:0]   byp_drop_cnt,
  output logic [CW-1:0]   tmo_cnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int PW = $clog2(N + 1);

  logic [1:0] rst_pipe;
  logic       rst_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe <= 2'b00;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  logic [N*DW-1:0] mapped;
  logic [IW-1:0]   cur;
  logic            fwd, is_trans, tmo_hit;
  logic [N-1:0]    byp_done;
  logic [PW-1:0]   byp_inc;

  eb_remap #(.N(N), .DW(DW), .ROUTE_MASK(ROUTE_MASK), .ROUTE_VAL(ROUTE_VAL)) u_remap (
    .route_mode (route_mode),
    .in_dest    (s_dest),
    .out_dest   (mapped)
  );

  eb_ctrl #(.N(N), .DW(DW), .TMO_CYC(TMO_CYC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (s_valid),
    .s_last     (s_last),
    .s_dest     (s_dest),
    .bypass     (bypass_en),
    .trans_dest (trans_dest),
    .m_ready    (m_ready),
    .s_ready    (s_ready),
    .cur        (cur),
    .fwd        (fwd),
    .is_trans   (is_trans),
    .tmo_hit    (tmo_hit)
  );

  assign m_valid = fwd;
  assign m_data  = s_data[cur*W +: W];
  assign m_last  = s_last[cur];
  assign m_dest  = is_trans ? s_dest[cur*DW +: DW] : mapped[cur*DW +: DW];

  always_comb begin
    byp_done = bypass_en & s_valid & s_last;
    byp_inc  = '0;
    for (int i = 0; i < N; i++) byp_inc = byp_inc + PW'(byp_done[i]);
  end

  eb_sat_cnt #(.W(CW), .IW(PW)) u_byp_cnt (
    .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (byp_inc), .cnt (byp_drop_cnt)
  );

  eb_sat_cnt #(.W(CW), .IW(1)) u_tmo_cnt (
    .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .inc (tmo_hit), .cnt (tmo_cnt)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> !m_valid);
  assert_index_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !is_trans && !route_mode) |-> m_dest == DW'(cur));
  assert_trans_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && is_trans) |-> m_dest == trans_dest);
  assert_bypass_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready & bypass_en) == bypass_en);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid && $stable(m_data) && $stable(m_last) && $stable(m_dest));
endmodule

// File: tb/event_builder_tb.sv
module event_builder_tb;
  localparam int N = 3, W = 16, DW = 4, TMO = 64, D = 512;
  localparam logic [N*DW-1:0] RMASK = 12'h0FC;
  localparam logic [N*DW-1:0] RVAL  = 12'h0A4;
  localparam logic [DW-1:0]   TRANS = 4'hF;

  logic clk = 1'b0, arst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]    s_valid, s_ready, s_last;
  logic [N*W-1:0]  s_data;
  logic [N*DW-1:0] s_dest;
  logic            m_valid, m_last;
  logic            m_ready = 1'b1;
  logic [W-1:0]    m_data;
  logic [DW-1:0]   m_dest;
  logic [N-1:0]    bypass_en = '0;
  logic            route_mode = 1'b0, cnt_clr = 1'b0;
  logic [31:0]     byp_drop_cnt, tmo_cnt;

  event_builder #(.N(N), .W(W), .DW(DW), .TMO_CYC(TMO)) u_dut (
    .clk(clk), .arst_n(arst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_dest(s_dest), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_last(m_last), .m_dest(m_dest), .bypass_en(bypass_en),
    .route_mode(route_mode), .trans_dest(TRANS), .cnt_clr(cnt_clr),
    .byp_drop_cnt(byp_drop_cnt), .tmo_cnt(tmo_cnt));

  logic [W-1:0]  sd [N][D];
  logic [DW-1:0] sg [N][D];
  logic          sl [N][D];
  int            wr [N];
  int            rd [N];
  logic [N-1:0]  acc;

  logic [W-1:0]  ed [2048];
  logic [DW-1:0] eg [2048];
  logic          el [2048];
  int ewr = 0, erd = 0;
  int n_chk = 0, n_err = 0, exp_byp = 0, exp_tmo = 0, cyc = 0;
  logic stall_en = 1'b0;
  logic cap_v, cap_l;
  logic [W-1:0] cap_d;
  logic [DW-1:0] cap_g;

  initial for (int i = 0; i < N; i++) begin wr[i] = 0; rd[i] = 0; end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      s_valid[i]          = rd[i] < wr[i];
      s_data[i*W +: W]    = sd[i][rd[i] % D];
      s_dest[i*DW +: DW]  = sg[i][rd[i] % D];
      s_last[i]           = sl[i][rd[i] % D];
    end
  end

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    acc   <= s_valid & s_ready;
    cap_v <= arst_n && m_valid && m_ready;
    cap_d <= m_data;
    cap_g <= m_dest;
    cap_l <= m_last;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    for (int i = 0; i < N; i++) if (acc[i]) rd[i] = rd[i] + 1;
    m_ready <= stall_en ? ($urandom % 4 != 0) : 1'b1;
    if (cap_v) begin
      if (erd >= ewr) check("R2 unexpected beat", {cap_g, cap_d}, '1);
      else begin
        check("R2/R8 data", cap_d, ed[erd]);
        check("R3/R4/R5 dest", cap_g, eg[erd]);
        check("R2 last", cap_l, el[erd]);
        erd++;
      end
    end
  end

  function automatic logic [DW-1:0] exp_dest(int i, logic [DW-1:0] d);
    logic [DW-1:0] mk, vl;
    mk = RMASK[i*DW +: DW];
    vl = RVAL[i*DW +: DW];
    return route_mode ? ((d & ~mk) | (vl & mk)) : DW'(i);
  endfunction

  task automatic push_src(int i, logic [W-1:0] d, logic [DW-1:0] g, logic l);
    sd[i][wr[i] % D] = d; sg[i][wr[i] % D] = g; sl[i][wr[i] % D] = l;
    wr[i] = wr[i] + 1;
  endtask

  task automatic push_exp(logic [W-1:0] d, logic [DW-1:0] g, logic l);
    ed[ewr] = d; eg[ewr] = g; el[ewr] = l; ewr++;
  endtask

  task automatic add_frame(int i, int len, logic [DW-1:0] g, logic emit, logic [DW-1:0] og);
    for (int b = 0; b < len; b++) begin
      logic [W-1:0] d;
      d = W'($urandom);
      push_src(i, d, g, b == len - 1);
      if (emit) push_exp(d, og, b == len - 1);
    end
  endtask

  task automatic add_event();
    for (int i = 0; i < N; i++) begin
      logic [DW-1:0] g;
      g = DW'($urandom % 15);
      add_frame(i, 1 + $urandom % 4, g, !bypass_en[i], exp_dest(i, g));
      if (bypass_en[i]) exp_byp++;
    end
  endtask

  task automatic wait_idle();
    bit busy;
    do begin
      @(negedge clk);
      busy = (erd != ewr);
      for (int i = 0; i < N; i++) if (rd[i] != wr[i]) busy = 1;
    end while (busy);
    repeat (4) @(negedge clk);
    check("R2 all expected beats seen", erd, ewr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 m_valid in reset", m_valid, 0);
    check("R1 byp cnt in reset", byp_drop_cnt, 0);
    arst_n = 1'b1;
    @(negedge clk);
    check("R1 m_valid after reset", m_valid, 0);
    check("R1 tmo cnt after reset", tmo_cnt, 0);
    repeat (3) @(negedge clk);

    // R2 R3 indexed events with random backpressure (R8)
    stall_en = 1'b1;
    for (int e = 0; e < 12; e++) add_event();
    wait_idle();

    // R4 routed mode
    route_mode = 1'b1;
    for (int e = 0; e < 12; e++) add_event();
    wait_idle();

    // R5 transition frame loaded with a complete event in the same cycle
    stall_en = 1'b0;
    route_mode = 1'b0;
    add_frame(1, 2, TRANS, 1'b1, TRANS);
    add_event();
    wait_idle();

    // R6 bypass of source 1
    stall_en = 1'b1;
    bypass_en = 3'b010;
    for (int e = 0; e < 8; e++) add_event();
    wait_idle();
    check("R6 bypass drop count", byp_drop_cnt, exp_byp);

    // R9 clear and increment in the same cycle
    add_frame(1, 1, 4'h3, 1'b0, 4'h0);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    @(negedge clk);
    check("R9 clear with increment", byp_drop_cnt, 1);
    cnt_clr = 1'b1;
    @(negedge clk);
    cnt_clr = 1'b0;
    @(negedge clk);
    check("R9 clear alone", byp_drop_cnt, 0);
    bypass_en = '0;
    exp_byp = 0;

    // R7 source 1 missing: frames on 0 and 2 time out
    add_frame(0, 3, 4'h2, 1'b0, 4'h0);
    add_frame(2, 2, 4'h5, 1'b0, 4'h0);
    repeat (TMO - 4) @(negedge clk);
    check("R7 no early drop", tmo_cnt, 0);
    wait_idle();
    check("R7 timeout count", tmo_cnt, 1);
    for (int e = 0; e < 4; e++) add_event();
    wait_idle();
    check("R7 no further timeout", tmo_cnt, 1);
    check("R6 no bypass drops", byp_drop_cnt, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule